// File: doc/BRIEF.md
# Serial Port Line Status Logic

This block keeps the line status flags of a host-facing serial port. It sits between a receive deserializer, a transmit shifter and the host register interface. Completed characters arrive as one-cycle events that carry their framing and parity check results. The block stores them in a receive queue and derives the data-ready, overrun, framing, parity and break flags. A host read of the status register clears the flags that are cleared on read. On the transmit side it tracks how many bytes the host has written and the shifter has not yet taken. From that count it drives the transmit-empty flag and its interrupt request.

Two operating modes exist. In single-buffer mode the receive and transmit holding stores each hold one character. In queue mode each holds up to its parameterised depth (16 by default). In queue mode, data-ready follows a host-selected trigger level. Error results stay attached to their own character. An overrun occurs only when the receive queue is full and one more character has been completely received. Break detection watches the raw receive line and counts bit-time ticks against a threshold that the current frame settings define.

Top module: `serial_line_status`

## Requirements
- R1: In single-buffer mode `st_dr` rises on the first clock edge after a character event and falls on the edge after a host RX read empties the buffer.
- R2: In queue mode `st_dr` is 1 exactly while the queue count is at least the trigger level; `rx_trig` codes 0, 1, 2, 3 select levels 1, 4, 8 and 14.
- R3: In single-buffer mode, a character event while an unread character is held sets `st_oe`, and the new character replaces the held one on `rx_head_data`.
- R4: In queue mode, `st_oe` sets only when the queue holds RX_DEPTH characters and a further character event arrives with no host read in that cycle; that character is dropped and the queued contents and order stay unchanged.
- R5: In single-buffer mode, a character with `rx_char_ferr` or `rx_char_perr` set makes `st_fe` or `st_pe` 1 two edges after its event; a host status read clears them.
- R6: In queue mode, a character's framing and parity results reach `st_fe` and `st_pe` only once that character is at the head of the queue, two edges after it becomes the head.
- R7: With `word_len` code c giving 5+c data bits, a frame of W = 1 + (5+c) + `parity_en` + (1 or 2 stop bits by `stop_two`) bits, `st_bi` sets on the (2W+4)-th `bit_tick` seen while `rx_line` stays 0, and not before.
- R8: A host status read clears `st_bi`, and it does not set again during the same low period; `rx_line` at 1 restarts the count.
- R9: When a flag's set event and a host status read fall in the same cycle, the flag ends up 1.
- R10: `st_thre` is 1 while no written byte is waiting. A host TX write clears it, and it sets when the shifter takes the last byte. The capacity is 1 in single-buffer mode and TX_DEPTH in queue mode, and writes beyond the capacity are ignored.
- R11: `thre_irq` is 1 exactly when `st_thre` and `thre_irq_en` are both 1.
- R12: After reset all receive flags are 0, `st_thre` is 1 and both queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 = queue mode, 0 = single-buffer mode; changed only during reset |
| rx_trig | input | 2 | Receive trigger level code |
| word_len | input | 2 | Data bits code (5 + code) |
| parity_en | input | 1 | Parity bit present in the frame |
| stop_two | input | 1 | Two stop bits instead of one |
| rx_char_valid | input | 1 | One-cycle complete-character event |
| rx_char_data | input | DATA_W | Received character |
| rx_char_ferr | input | 1 | Stop bit sampled as 0 for this character |
| rx_char_perr | input | 1 | Parity mismatch for this character |
| rx_line | input | 1 | Raw receive line |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| host_rx_rd | input | 1 | Host reads the receive buffer head |
| host_lsr_rd | input | 1 | Host reads the status register |
| host_tx_wr | input | 1 | Host writes a byte to the transmit buffer |
| tx_char_taken | input | 1 | Shifter takes one byte from the transmit buffer |
| thre_irq_en | input | 1 | Transmit-empty interrupt enable |
| rx_head_data | output | DATA_W | Character at the head of the receive buffer |
| st_dr | output | 1 | Data ready |
| st_oe | output | 1 | Overrun |
| st_pe | output | 1 | Parity error |
| st_fe | output | 1 | Framing error |
| st_bi | output | 1 | Break |
| st_thre | output | 1 | Transmit holding empty |
| thre_irq | output | 1 | Transmit-empty interrupt request |

## Verification
The assertions check several rules on every cycle. A single-buffer character event always leaves data-ready set. The queue count never exceeds its depth. A full-queue arrival freezes the count and raises overrun even when a status read lands in the same cycle. Overrun and break only rise after their own cause. A transmit write without a take always clears transmit-empty. Other behaviours need the bench's ordered scenarios: the trigger-level sweep over every fill level, the exact tick at which break fires for all sixteen frame settings, error flags waiting until their character reaches the head, and the queue contents surviving an overrun.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

   // sticky flag slots in the top's flag vector
   localparam int FLG_OE  = 0;
   localparam int FLG_PE  = 1;
   localparam int FLG_FE  = 2;
   localparam int FLG_BI  = 3;
   localparam int FLG_NUM = 4;

   // longest frame: start + 8 data + parity + 2 stop
   localparam int MAX_FRAME_BITS = 12;

   // bits in one frame for the given settings
   function automatic logic [4:0] frame_bits(input logic [1:0] wl,
                                             input logic       par,
                                             input logic       stop2);
      return 5'd7 + {3'b000, wl} + {4'b0000, par} + {4'b0000, stop2};
   endfunction

endpackage

// File: rtl/lsr_rx_queue.sv
module lsr_rx_queue #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              single_mode,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              push_fe,
   input  logic              push_pe,
   input  logic              pop_req,
   output logic [CNT_W-1:0]  count,
   output logic [DATA_W-1:0] head_data,
   output logic              head_fe,
   output logic              head_pe,
   output logic              head_new,
   output logic              ovr_evt
);

   localparam int ENT_W = DATA_W + 2;

   logic [ENT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_inc, wr_inc;
   logic [CNT_W-1:0] count_nxt;
   logic             cap_full, host_pop, drop_old, do_pop, do_push;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign rd_inc = rd_ptr + PTR_W'(1);
         assign wr_inc = wr_ptr + PTR_W'(1);
      end else begin : g_cmp_wrap
         assign rd_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
         assign wr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      end
   endgenerate

   always_comb begin
      cap_full = single_mode ? (count != '0) : (count == CNT_W'(DEPTH));
      host_pop = pop_req && (count != '0);
      // single buffer: an unread character is replaced by the newcomer
      drop_old = single_mode && push && cap_full && !host_pop;
      do_pop   = host_pop || drop_old;
      do_push  = push && (!cap_full || do_pop);
      ovr_evt  = push && cap_full && !host_pop;
      unique case ({do_push, do_pop})
         2'b10:   count_nxt = count + CNT_W'(1);
         2'b01:   count_nxt = count - CNT_W'(1);
         default: count_nxt = count;
      endcase
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= {push_fe, push_pe, push_data};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr   <= '0;
         wr_ptr   <= '0;
         count    <= '0;
         head_new <= 1'b0;
      end else begin
         if (do_pop)  rd_ptr <= rd_inc;
         if (do_push) wr_ptr <= wr_inc;
         count    <= count_nxt;
         head_new <= (count_nxt != '0) && ((count == '0) || do_pop);
      end
   end

   assign head_data = mem[rd_ptr][DATA_W-1:0];
   assign head_pe   = mem[rd_ptr][DATA_W];
   assign head_fe   = mem[rd_ptr][DATA_W+1];

endmodule

// File: rtl/lsr_break_watch.sv
module lsr_break_watch #(
   parameter int CNT_W = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_line,
   input  logic       bit_tick,
   input  logic [1:0] word_len,
   input  logic       parity_en,
   input  logic       stop_two,
   output logic       brk_evt
);
   import lsr_pkg::*;

   logic [4:0]       fbits;
   logic [CNT_W-1:0] thr, low_cnt;

   always_comb begin
      fbits   = frame_bits(word_len, parity_en, stop_two);
      thr     = CNT_W'({fbits, 1'b0}) + CNT_W'(3);
      brk_evt = !rx_line && bit_tick && (low_cnt == thr);
   end

   // counts ticks of one low period, stops one past the threshold
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          low_cnt <= '0;
      else if (rx_line)                    low_cnt <= '0;
      else if (bit_tick && low_cnt <= thr) low_cnt <= low_cnt + CNT_W'(1);
   end

endmodule

// File: rtl/lsr_tx_track.sv
module lsr_tx_track #(
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic single_mode,
   input  logic host_wr,
   input  logic take,
   output logic empty
);

   logic [CNT_W-1:0] count, cap;
   logic             wr_ok, take_ok;

   always_comb begin
      cap     = single_mode ? CNT_W'(1) : CNT_W'(DEPTH);
      take_ok = take && (count != '0);
      wr_ok   = host_wr && ((count < cap) || take_ok);
      empty   = (count == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else begin
         unique case ({wr_ok, take_ok})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/lsr_sticky_flag.sv
module lsr_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);

   // a set in the same cycle as a clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

endmodule

// File: rtl/serial_line_status.sv
module serial_line_status #(
   parameter int DATA_W    = 8,
   parameter int RX_DEPTH  = 16,
   parameter int TX_DEPTH  = 16,
   parameter int TRIG_LVL0 = 1,
   parameter int TRIG_LVL1 = 4,
   parameter int TRIG_LVL2 = 8,
   parameter int TRIG_LVL3 = 14,
   parameter int BRK_CNT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_mode,
   input  logic [1:0]        rx_trig,
   input  logic [1:0]        word_len,
   input  logic              parity_en,
   input  logic              stop_two,
   input  logic              rx_char_valid,
   input  logic [DATA_W-1:0] rx_char_data,
   input  logic              rx_char_ferr,
   input  logic              rx_char_perr,
   input  logic              rx_line,
   input  logic              bit_tick,
   input  logic              host_rx_rd,
   input  logic              host_lsr_rd,
   input  logic              host_tx_wr,
   input  logic              tx_char_taken,
   input  logic              thre_irq_en,
   output logic [DATA_W-1:0] rx_head_data,
   output logic              st_dr,
   output logic              st_oe,
   output logic              st_pe,
   output logic              st_fe,
   output logic              st_bi,
   output logic              st_thre,
   output logic              thre_irq
);
   import lsr_pkg::*;

   localparam int RXC_W = $clog2(RX_DEPTH + 1);

   // elaboration-time parameter checks
   generate
      if (RX_DEPTH < 2)       begin : g_bad_rxd  $error("RX_DEPTH must be at least 2"); end
      if (TX_DEPTH < 1)       begin : g_bad_txd  $error("TX_DEPTH must be at least 1"); end
      if (DATA_W < 5)         begin : g_bad_dw   $error("DATA_W must be at least 5"); end
      if (TRIG_LVL0 < 1 || TRIG_LVL0 > RX_DEPTH ||
          TRIG_LVL1 < 1 || TRIG_LVL1 > RX_DEPTH ||
          TRIG_LVL2 < 1 || TRIG_LVL2 > RX_DEPTH ||
          TRIG_LVL3 < 1 || TRIG_LVL3 > RX_DEPTH)
                              begin : g_bad_trig $error("trigger levels must lie in 1..RX_DEPTH"); end
      if ((1 << BRK_CNT_W) <= 2 * MAX_FRAME_BITS + 4)
                              begin : g_bad_brk  $error("BRK_CNT_W too narrow for the break threshold"); end
   endgenerate

   logic [RXC_W-1:0]   rx_count, dr_lvl;
   logic               head_fe, head_pe, head_new, ovr_evt, brk_evt, tx_empty;
   logic [FLG_NUM-1:0] flag_set, flag_q;

   lsr_rx_queue #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk        (clk),
      .rst_n      (rst_n),
      .single_mode(!fifo_mode),
      .push       (rx_char_valid),
      .push_data  (rx_char_data),
      .push_fe    (rx_char_ferr),
      .push_pe    (rx_char_perr),
      .pop_req    (host_rx_rd),
      .count      (rx_count),
      .head_data  (rx_head_data),
      .head_fe    (head_fe),
      .head_pe    (head_pe),
      .head_new   (head_new),
      .ovr_evt    (ovr_evt)
   );

   lsr_break_watch #(.CNT_W(BRK_CNT_W)) u_brk (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_line  (rx_line),
      .bit_tick (bit_tick),
      .word_len (word_len),
      .parity_en(parity_en),
      .stop_two (stop_two),
      .brk_evt  (brk_evt)
   );

   lsr_tx_track #(.DEPTH(TX_DEPTH)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .single_mode(!fifo_mode),
      .host_wr    (host_tx_wr),
      .take       (tx_char_taken),
      .empty      (tx_empty)
   );

   always_comb begin
      flag_set         = '0;
      flag_set[FLG_OE] = ovr_evt;
      flag_set[FLG_PE] = head_new && head_pe;
      flag_set[FLG_FE] = head_new && head_fe;
      flag_set[FLG_BI] = brk_evt;
   end

   generate
      for (genvar gi = 0; gi < FLG_NUM; gi++) begin : g_flag
         lsr_sticky_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (flag_set[gi]),
            .clr  (host_lsr_rd),
            .q    (flag_q[gi])
         );
      end
   endgenerate

   always_comb begin
      if (!fifo_mode) dr_lvl = RXC_W'(1);
      else begin
         unique case (rx_trig)
            2'd0:    dr_lvl = RXC_W'(TRIG_LVL0);
            2'd1:    dr_lvl = RXC_W'(TRIG_LVL1);
            2'd2:    dr_lvl = RXC_W'(TRIG_LVL2);
            default: dr_lvl = RXC_W'(TRIG_LVL3);
         endcase
      end
   end

   assign st_dr    = (rx_count >= dr_lvl);
   assign st_oe    = flag_q[FLG_OE];
   assign st_pe    = flag_q[FLG_PE];
   assign st_fe    = flag_q[FLG_FE];
   assign st_bi    = flag_q[FLG_BI];
   assign st_thre  = tx_empty;
   assign thre_irq = tx_empty && thre_irq_en;

endmodule

// File: rtl/serial_line_status_chk.sv
module serial_line_status_chk #(
   parameter int RX_DEPTH = 16,
   parameter int RXC_W    = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fifo_mode,
   input logic             rx_char_valid,
   input logic             host_rx_rd,
   input logic             host_lsr_rd,
   input logic             host_tx_wr,
   input logic             tx_char_taken,
   input logic             rx_line,
   input logic             bit_tick,
   input logic [RXC_W-1:0] rx_count,
   input logic             st_dr,
   input logic             st_oe,
   input logic             st_bi,
   input logic             st_thre
);

   p_single_dr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_mode && rx_char_valid) |=> st_dr);

   p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= RXC_W'(RX_DEPTH));

   p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_mode && rx_char_valid && !host_rx_rd && rx_count == RXC_W'(RX_DEPTH))
      |=> ($stable(rx_count) && st_oe));

   p_oe_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_oe) |-> $past(rx_char_valid));

   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_lsr_rd && !fifo_mode && rx_char_valid && !host_rx_rd && rx_count != '0)
      |=> st_oe);

   p_bi_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_bi) |-> $past(!rx_line && bit_tick));

   p_thre_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_tx_wr && !tx_char_taken) |=> !st_thre);

endmodule

bind serial_line_status serial_line_status_chk #(.RX_DEPTH(RX_DEPTH), .RXC_W(RXC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fifo_mode    (fifo_mode),
   .rx_char_valid(rx_char_valid),
   .host_rx_rd   (host_rx_rd),
   .host_lsr_rd  (host_lsr_rd),
   .host_tx_wr   (host_tx_wr),
   .tx_char_taken(tx_char_taken),
   .rx_line      (rx_line),
   .bit_tick     (bit_tick),
   .rx_count     (rx_count),
   .st_dr        (st_dr),
   .st_oe        (st_oe),
   .st_bi        (st_bi),
   .st_thre      (st_thre)
);

// File: tb/test_serial_line_status.sv
module test_serial_line_status;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_mode = 1'b0;
   logic [1:0] rx_trig = 2'd0;
   logic [1:0] word_len = 2'd3;
   logic       parity_en = 1'b0;
   logic       stop_two = 1'b0;
   logic       rx_char_valid = 1'b0;
   logic [7:0] rx_char_data = 8'h00;
   logic       rx_char_ferr = 1'b0;
   logic       rx_char_perr = 1'b0;
   logic       rx_line = 1'b1;
   logic       bit_tick = 1'b0;
   logic       host_rx_rd = 1'b0;
   logic       host_lsr_rd = 1'b0;
   logic       host_tx_wr = 1'b0;
   logic       tx_char_taken = 1'b0;
   logic       thre_irq_en = 1'b0;
   logic [7:0] rx_head_data;
   logic       st_dr, st_oe, st_pe, st_fe, st_bi, st_thre, thre_irq;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   serial_line_status i_serial_line_status (
      .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rx_trig(rx_trig),
      .word_len(word_len), .parity_en(parity_en), .stop_two(stop_two),
      .rx_char_valid(rx_char_valid), .rx_char_data(rx_char_data),
      .rx_char_ferr(rx_char_ferr), .rx_char_perr(rx_char_perr),
      .rx_line(rx_line), .bit_tick(bit_tick), .host_rx_rd(host_rx_rd),
      .host_lsr_rd(host_lsr_rd), .host_tx_wr(host_tx_wr),
      .tx_char_taken(tx_char_taken), .thre_irq_en(thre_irq_en),
      .rx_head_data(rx_head_data), .st_dr(st_dr), .st_oe(st_oe),
      .st_pe(st_pe), .st_fe(st_fe), .st_bi(st_bi), .st_thre(st_thre),
      .thre_irq(thre_irq)
   );

   task automatic check(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   task automatic cyc(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic fm);
      rst_n = 1'b0; fifo_mode = fm;
      rx_char_valid = 0; host_rx_rd = 0; host_lsr_rd = 0; host_tx_wr = 0;
      tx_char_taken = 0; bit_tick = 0; rx_line = 1; thre_irq_en = 0;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
   endtask

   task automatic push(input int d, input logic fe, input logic pe);
      rx_char_valid = 1; rx_char_data = d[7:0]; rx_char_ferr = fe; rx_char_perr = pe;
      cyc();
      rx_char_valid = 0; rx_char_ferr = 0; rx_char_perr = 0;
   endtask

   task automatic rx_rd();  host_rx_rd = 1;    cyc(); host_rx_rd = 0;    endtask
   task automatic lsr_rd(); host_lsr_rd = 1;   cyc(); host_lsr_rd = 0;   endtask
   task automatic tx_wr();  host_tx_wr = 1;    cyc(); host_tx_wr = 0;    endtask
   task automatic tx_take(); tx_char_taken = 1; cyc(); tx_char_taken = 0; endtask
   task automatic tick();   bit_tick = 1;      cyc(); bit_tick = 0;      endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0 (run hung)");
      summary();
   end

   initial begin
      // ---------------- reset state (R12)
      do_reset(1'b0);
      check("R12 dr", st_dr, 0);
      check("R12 oe", st_oe, 0);
      check("R12 pe", st_pe, 0);
      check("R12 fe", st_fe, 0);
      check("R12 bi", st_bi, 0);
      check("R12 thre", st_thre, 1);

      // ---------------- single-buffer receive (R1, R5, R3, R9)
      push(8'h5A, 0, 0);
      check("R1 dr after char", st_dr, 1);
      check("R1 head data", rx_head_data, 8'h5A);
      rx_rd();
      check("R1 dr after read", st_dr, 0);

      push(8'h11, 1, 0);
      cyc(1);
      check("R5 fe set", st_fe, 1);
      check("R5 pe clean", st_pe, 0);
      lsr_rd();
      check("R5 fe cleared", st_fe, 0);
      rx_rd();
      push(8'h22, 0, 1);
      cyc(1);
      check("R5 pe set", st_pe, 1);
      check("R5 fe clean", st_fe, 0);

      host_lsr_rd = 1;
      push(8'h33, 0, 0);
      host_lsr_rd = 0;
      check("R9 oe set beats read", st_oe, 1);
      check("R3 newcomer replaces", rx_head_data, 8'h33);
      check("R3 pe cleared by read", st_pe, 0);
      lsr_rd();
      check("R3 oe cleared", st_oe, 0);

      // ---------------- queue mode trigger sweep (R2) and overrun (R4)
      for (int tg = 0; tg < 4; tg++) begin
         int lvl;
         lvl = (tg == 0) ? 1 : (tg == 1) ? 4 : (tg == 2) ? 8 : 14;
         do_reset(1'b1);
         rx_trig = tg[1:0];
         check("R2 dr empty", st_dr, 0);
         for (int n = 1; n <= 16; n++) begin
            push(n, 0, 0);
            check($sformatf("R2 dr trig%0d count%0d", tg, n), st_dr, (n >= lvl) ? 1 : 0);
         end
         if (tg == 3) begin
            check("R4 no overrun yet", st_oe, 0);
            push(8'hEE, 0, 0);
            check("R4 overrun on full", st_oe, 1);
            for (int k = 1; k <= 16; k++) begin
               check($sformatf("R4 kept entry %0d", k), rx_head_data, k);
               rx_rd();
            end
            check("R4 drained", st_dr, 0);
         end
      end

      // ---------------- error flags travel with their character (R6)
      do_reset(1'b1);
      rx_trig = 2'd0;
      push(8'hA1, 0, 0);
      push(8'hB2, 1, 1);
      cyc(2);
      check("R6 fe held back", st_fe, 0);
      check("R6 pe held back", st_pe, 0);
      rx_rd();
      cyc(1);
      check("R6 fe at head", st_fe, 1);
      check("R6 pe at head", st_pe, 1);
      check("R6 head is errored char", rx_head_data, 8'hB2);

      // ---------------- break threshold over all frame settings (R7, R8)
      do_reset(1'b0);
      for (int wl = 0; wl < 4; wl++)
         for (int pa = 0; pa < 2; pa++)
            for (int s2 = 0; s2 < 2; s2++) begin
               int w, thr;
               rx_line = 1;
               word_len = wl[1:0]; parity_en = pa[0]; stop_two = s2[0];
               cyc(1);
               lsr_rd();
               w   = 1 + 5 + wl + pa + 1 + s2;
               thr = 2 * w + 3;
               rx_line = 0;
               for (int t = 0; t < thr; t++) tick();
               check($sformatf("R7 no break at %0d ticks", thr), st_bi, 0);
               tick();
               check($sformatf("R7 break at %0d ticks", thr + 1), st_bi, 1);
               lsr_rd();
               check("R8 break cleared", st_bi, 0);
               tick(); tick(); tick();
               check("R8 no repeat in same low run", st_bi, 0);
            end
      rx_line = 1;
      cyc(1);

      // ---------------- transmit empty (R10, R11)
      do_reset(1'b0);
      tx_wr();
      check("R10 write clears thre", st_thre, 0);
      tx_wr();
      tx_take();
      check("R10 single capacity one", st_thre, 1);
      thre_irq_en = 1;
      cyc(1);
      check("R11 irq with enable", thre_irq, 1);
      tx_wr();
      check("R11 irq drops when busy", thre_irq, 0);
      tx_take();
      thre_irq_en = 0;
      cyc(1);
      check("R11 irq masked", thre_irq, 0);

      do_reset(1'b1);
      for (int k = 0; k < 17; k++) tx_wr();
      for (int k = 0; k < 15; k++) tx_take();
      check("R10 queue still holds one", st_thre, 0);
      tx_take();
      check("R10 queue empty after 16", st_thre, 1);

      summary();
   end

endmodule